// File: doc/BRIEF.md
# SD Command Issue and Response Capture

This block is the command front end of an SD host controller. Software writes five bytes, one after another, to a single command port. The first byte is the command index and the next four are the 32-bit argument, most significant byte first. The fifth write builds a 48-bit command frame and raises a busy flag. The frame is then shifted out on a single serial line, one bit per clock. The frame holds a start bit of 0, a transmission bit of 1, the 6-bit index, the argument, a 7-bit check field and an end bit of 1. The check field is left at zero because CRC generation is not part of this block.

A response can be requested when the command is issued, either short (48 bits on the line) or long (136 bits on the line). After the end bit the block waits a bounded time for the card's start bit. It then captures the response payload into a 16-byte buffer that software reads by index. It records whether the last response was long, and it sets a done bit or a timeout bit in a status byte. Status bits stay set until software reads the status, and a command issued while the engine is still busy is dropped and recorded in a sticky overrun flag.

Top module: `sd_cmd_front`

## Requirements
- R1: The fifth write to the command port produces `cmd_frame` = {2'b01, byte1[5:0], byte2, byte3, byte4, byte5, 7'b0, 1'b1}. Here byte1 is the first byte written and byte2..byte5 are argument bits 31:24 down to 7:0. The top two bits of the first byte are ignored.
- R2: `cmd_line` is high whenever no frame is being sent. Frame bit 47 drives the line in the clock cycle after the edge that takes the fifth write, and each later bit follows one cycle after the one before, down to bit 0.
- R3: `busy` rises at the edge that takes the fifth write and stays high until the command completes.
- R4: With no response requested, `busy` falls one cycle after frame bit 0 has been driven (48 cycles after the launch edge), and status bit 0 (done) is set.
- R5: A short response's 32 payload bits (line bits 39:8) land in buffer bytes 12..15, with byte 12 the most significant. Bytes 0..11 read zero because the buffer is cleared at every launch. `resp_len` then reads 0 and status bit 0 is set.
- R6: A long response's 128 bits after the first eight line bits fill bytes 0..15 in arrival order, with byte 0 the most significant. `resp_len` then reads 1 and status bit 0 is set.
- R7: The start bit (line low) is accepted if the card drives it in any of the 64 cycles that follow the end-bit cycle. If the line stays high through all 64, `busy` falls and status bit 3 (timeout) is set, with bit 0 left clear.
- R8: A fifth write while `busy` is high is ignored: the frame in flight and `busy` are unchanged. It sets `overrun`, which stays set until `soft_rst`.
- R9: `soft_rst` returns the byte counter to zero and idles the engine, so bytes written before it never become part of a launched frame.
- R10: Status bits hold their value until a cycle with `stat_rd` high. They read zero from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the serial line runs at one bit per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| soft_rst | input | 1 | Synchronous soft reset of counter, flags and engine |
| wr_en | input | 1 | Write strobe for the command port |
| wr_data | input | 8 | Command port byte |
| rsp_en | input | 1 | A response is expected (sampled at launch) |
| rsp_long | input | 1 | Expected response is 136 bits (sampled at launch) |
| cmd_in | input | 1 | Serial response line from the card |
| cmd_line | output | 1 | Serial command line to the card |
| cmd_frame | output | 48 | Frame of the last accepted command |
| busy | output | 1 | Command traffic in progress |
| resp_idx | input | 4 | Response buffer byte index |
| resp_byte | output | 8 | Response buffer byte at `resp_idx` |
| resp_len | output | 1 | 0 after a short response, 1 after a long one |
| stat_rd | input | 1 | Status read strobe; clears the status |
| stat_q | output | 8 | Status: bit 0 done, bit 3 timeout |
| overrun | output | 1 | Sticky: a launch was dropped while busy |

## Verification
Counting from the edge that takes the fifth write, `busy` and `cmd_frame` change at that edge. Frame bit 47-k is on the line in cycle k after it. A command with no response frees the engine 48 edges later. A start bit driven d cycles after the end-bit cycle is sampled at the following edge, so d = 63 is the last accepted delay. With no start bit, the timeout lands at edge 112. Inputs are driven and outputs sampled on the falling edge, and each check is placed on the falling edge just before and just after the rising edge where the change is due. For example, `busy` is checked still high on the negedge that drives the last response bit and low on the next one. Buffer bytes are read combinationally by index once the engine is idle.

// File: rtl/sd_cmd_front.sv
module sd_cmd_front #(
  parameter int TMO        = 64,
  parameter int SHORT_BITS = 48,
  parameter int LONG_BITS  = 136
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        soft_rst,
  input  logic        wr_en,
  input  logic [7:0]  wr_data,
  input  logic        rsp_en,
  input  logic        rsp_long,
  input  logic        cmd_in,
  output logic        cmd_line,
  output logic [47:0] cmd_frame,
  output logic        busy,
  input  logic [3:0]  resp_idx,
  output logic [7:0]  resp_byte,
  output logic        resp_len,
  input  logic        stat_rd,
  output logic [7:0]  stat_q,
  output logic        overrun
);
  localparam int BW = $clog2(LONG_BITS + 1);
  localparam int TW = $clog2(TMO);
  localparam logic [BW-1:0] TX_LAST   = BW'(47);
  localparam logic [BW-1:0] CAP_FIRST = BW'(8);
  localparam logic [TW-1:0] W_LAST    = TW'(TMO - 1);

  typedef enum logic [1:0] {IDLE, SEND, WAIT, RECV} st_t;
  st_t st;

  logic [2:0]    cnt;
  logic [5:0]    op_q;
  logic [23:0]   arg_q;
  logic [47:0]   sh;
  logic [BW-1:0] bitcnt;
  logic [TW-1:0] wcnt;
  logic          want_rsp, want_long;
  logic [127:0]  rbuf;

  wire [47:0]   frame   = {2'b01, op_q, arg_q, wr_data, 7'd0, 1'b1};
  wire [BW-1:0] rx_last = want_long ? BW'(LONG_BITS - 1) : BW'(SHORT_BITS - 1);
  wire [BW-1:0] cap_end = want_long ? BW'(LONG_BITS) : BW'(SHORT_BITS - 8);
  wire [6:0]    sel     = {~resp_idx, 3'b000};

  assign busy      = (st != IDLE);
  assign cmd_line  = (st == SEND) ? sh[47] : 1'b1;
  assign resp_byte = rbuf[sel +: 8];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= IDLE; cnt <= '0; op_q <= '0; arg_q <= '0; sh <= '1;
      bitcnt <= '0; wcnt <= '0; want_rsp <= 1'b0; want_long <= 1'b0;
      rbuf <= '0; cmd_frame <= '0; resp_len <= 1'b0; stat_q <= '0;
      overrun <= 1'b0;
    end else if (soft_rst) begin
      st <= IDLE; cnt <= '0; stat_q <= '0; overrun <= 1'b0;
    end else begin
      if (stat_rd) stat_q <= '0;
      if (wr_en) begin
        if (cnt == 3'd0) op_q <= wr_data[5:0];
        else if (cnt != 3'd4) arg_q <= {arg_q[15:0], wr_data};
        cnt <= (cnt == 3'd4) ? 3'd0 : cnt + 3'd1;
        if (cnt == 3'd4) begin
          if (busy) overrun <= 1'b1;
          else begin
            st <= SEND; sh <= frame; cmd_frame <= frame; bitcnt <= '0;
            want_rsp <= rsp_en; want_long <= rsp_long; rbuf <= '0;
          end
        end
      end
      case (st)
        SEND: begin
          if (bitcnt == TX_LAST) begin
            bitcnt <= '0; wcnt <= '0;
            if (want_rsp) st <= WAIT;
            else begin st <= IDLE; stat_q[0] <= 1'b1; end
          end else begin
            bitcnt <= bitcnt + 1'b1; sh <= {sh[46:0], 1'b1};
          end
        end
        WAIT: begin
          if (!cmd_in) begin st <= RECV; bitcnt <= BW'(1); end
          else if (wcnt == W_LAST) begin st <= IDLE; stat_q[3] <= 1'b1; end
          else wcnt <= wcnt + 1'b1;
        end
        RECV: begin
          if (bitcnt >= CAP_FIRST && bitcnt < cap_end) rbuf <= {rbuf[126:0], cmd_in};
          if (bitcnt == rx_last) begin
            st <= IDLE; resp_len <= want_long; stat_q[0] <= 1'b1;
          end else bitcnt <= bitcnt + 1'b1;
        end
        default: ;
      endcase
    end
  end
endmodule

module sd_cmd_front_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        soft_rst,
  input logic        wr_en,
  input logic [2:0]  cnt,
  input logic        busy,
  input logic        cmd_line,
  input logic [47:0] cmd_frame,
  input logic        overrun,
  input logic [7:0]  stat_q
);
  AST_LAUNCH_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && cnt == 3'd4 && !busy && !soft_rst) |=> busy); // R3
  AST_IDLE_LINE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> cmd_line); // R2
  AST_DROP_SETS_OVERRUN: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && cnt == 3'd4 && busy && !soft_rst) |=> overrun); // R8
  AST_OVERRUN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (overrun && !soft_rst) |=> overrun); // R8
  AST_FRAME_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(cmd_frame)); // R8
  AST_TIMEOUT_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat_q[3]) |-> $fell(busy)); // R7
  AST_COUNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= 3'd4); // R9
endmodule

bind sd_cmd_front sd_cmd_front_chk u_chk (
  .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .wr_en(wr_en), .cnt(cnt),
  .busy(busy), .cmd_line(cmd_line), .cmd_frame(cmd_frame),
  .overrun(overrun), .stat_q(stat_q)
);

// File: tb/sd_cmd_front_test.sv
module sd_cmd_front_test;
  logic clk = 1'b0, rst_n = 1'b0, soft_rst = 1'b0, wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic rsp_en = 1'b0, rsp_long = 1'b0, cmd_in = 1'b1, stat_rd = 1'b0;
  logic [3:0] resp_idx = '0;
  logic cmd_line, busy, resp_len, overrun;
  logic [47:0] cmd_frame;
  logic [7:0] resp_byte, stat_q;
  int n_chk = 0, n_fail = 0;

  sd_cmd_front uut (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .wr_en(wr_en),
    .wr_data(wr_data), .rsp_en(rsp_en), .rsp_long(rsp_long), .cmd_in(cmd_in),
    .cmd_line(cmd_line), .cmd_frame(cmd_frame), .busy(busy),
    .resp_idx(resp_idx), .resp_byte(resp_byte), .resp_len(resp_len),
    .stat_rd(stat_rd), .stat_q(stat_q), .overrun(overrun)
  );

  always #2 clk = ~clk;

  task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [47:0] exp_frame(input logic [7:0] op, input logic [31:0] arg);
    return {2'b01, op[5:0], arg, 7'd0, 1'b1};
  endfunction

  task automatic write5(input logic [7:0] op, input logic [31:0] arg);
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      wr_en = 1'b1;
      wr_data = (i == 0) ? op : arg[39 - 8*i -: 8];
    end
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // issue, then capture the serial frame; returns at the negedge showing bit 0
  task automatic issue(input logic [7:0] op, input logic [31:0] arg, input string req);
    logic [47:0] got;
    write5(op, arg);
    check("R3 busy after fifth write", 128'(busy), 128'(1));
    check({req, " frame"}, 128'(cmd_frame), 128'(exp_frame(op, arg)));
    for (int k = 0; k < 48; k++) begin
      if (k > 0) @(negedge clk);
      got[47 - k] = cmd_line;
    end
    check("R2 serial order", 128'(got), 128'(exp_frame(op, arg)));
  endtask

  task automatic respond(input logic [135:0] v, input int n, input int d, input string req);
    repeat (d + 1) @(negedge clk);
    for (int k = 0; k < n; k++) begin
      if (k > 0) @(negedge clk);
      cmd_in = v[n - 1 - k];
    end
    check({req, " busy on last bit"}, 128'(busy), 128'(1));
    @(negedge clk);
    cmd_in = 1'b1;
    check({req, " busy cleared"}, 128'(busy), 128'(0));
    check({req, " done bit"}, 128'(stat_q[0]), 128'(1));
  endtask

  task automatic read_status;
    @(negedge clk); stat_rd = 1'b1;
    @(negedge clk); stat_rd = 1'b0;
  endtask

  task automatic t_reset;
    check("R2 reset line", 128'(cmd_line), 128'(1));
    check("R3 reset busy", 128'(busy), 128'(0));
    check("R10 reset status", 128'(stat_q), 128'(0));
    check("R8 reset overrun", 128'(overrun), 128'(0));
    check("R5 reset resp_len", 128'(resp_len), 128'(0));
  endtask

  task automatic t_no_rsp;
    rsp_en = 1'b0;
    issue(8'hC0, 32'h0000_0000, "R1 no-rsp");
    check("R4 busy at bit 0", 128'(busy), 128'(1));
    @(negedge clk);
    check("R4 busy cleared", 128'(busy), 128'(0));
    check("R4 done bit", 128'(stat_q), 128'(8'h01));
    @(negedge clk); stat_rd = 1'b1;
    check("R10 held before read", 128'(stat_q), 128'(8'h01));
    @(negedge clk); stat_rd = 1'b0;
    check("R10 cleared by read", 128'(stat_q), 128'(0));
  endtask

  task automatic t_short(input logic [31:0] st, input int d);
    rsp_en = 1'b1; rsp_long = 1'b0;
    issue(8'd17, 32'h1234_5678, "R1 short");
    respond(136'({2'b00, 6'd17, st, 7'h55, 1'b1}), 48, d, "R5");
    check("R5 resp_len", 128'(resp_len), 128'(0));
    for (int i = 0; i < 16; i++) begin
      resp_idx = 4'(i); #1;
      check("R5 byte", 128'(resp_byte), 128'((i < 12) ? 8'h00 : st[127 - 8*i -: 8]));
    end
    read_status();
  endtask

  task automatic t_long(input logic [127:0] lv, input int d);
    rsp_en = 1'b1; rsp_long = 1'b1;
    issue(8'd2, 32'hFFFF_0001, "R1 long");
    respond({2'b00, 6'h3F, lv}, 136, d, "R6");
    check("R6 resp_len", 128'(resp_len), 128'(1));
    for (int i = 0; i < 16; i++) begin
      resp_idx = 4'(i); #1;
      check("R6 byte", 128'(resp_byte), 128'(lv[127 - 8*i -: 8]));
    end
    read_status();
  endtask

  task automatic t_timeout;
    rsp_en = 1'b1; rsp_long = 1'b0;
    issue(8'd8, 32'h0000_01AA, "R1 timeout");
    repeat (64) @(negedge clk);
    check("R7 busy through window", 128'(busy), 128'(1));
    @(negedge clk);
    check("R7 busy after window", 128'(busy), 128'(0));
    check("R7 timeout status", 128'(stat_q), 128'(8'h08));
    read_status();
  endtask

  task automatic t_overrun;
    rsp_en = 1'b1; rsp_long = 1'b0;
    write5(8'd5, 32'hA5A5_A5A5);
    write5(8'd6, 32'h0F0F_0F0F);
    check("R8 overrun set", 128'(overrun), 128'(1));
    check("R8 frame kept", 128'(cmd_frame), 128'(exp_frame(8'd5, 32'hA5A5_A5A5)));
    check("R8 still busy", 128'(busy), 128'(1));
    for (int i = 0; i < 400 && busy; i++) @(negedge clk);
    check("R8 sticky after end", 128'(overrun), 128'(1));
    read_status();
    check("R8 sticky after status read", 128'(overrun), 128'(1));
    @(negedge clk); soft_rst = 1'b1;
    @(negedge clk); soft_rst = 1'b0;
    check("R8 cleared by soft reset", 128'(overrun), 128'(0));
  endtask

  task automatic t_partial;
    rsp_en = 1'b0;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); wr_en = 1'b1; wr_data = 8'h09 + 8'(i);
    end
    @(negedge clk); wr_en = 1'b0; soft_rst = 1'b1;
    @(negedge clk); soft_rst = 1'b0;
    check("R9 no launch from partial", 128'(busy), 128'(0));
    issue(8'd13, 32'h0102_0304, "R9 fresh sequence");
    @(negedge clk);
    read_status();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_no_rsp();
    t_short(32'hDEAD_BEEF, 5);
    t_long(128'h0011_2233_4455_6677_8899_AABB_CCDD_EEFF, 63);
    t_short(32'h0000_0900, 0);
    t_timeout();
    t_overrun();
    t_partial();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(4 * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule